// File: doc/BRIEF.md
# Linear Frequency Ramp Generator

This block moves a signed frequency-offset word in a straight line from its present value to a new target value. When the word does not need to change, the output simply follows the frequency the surrounding loop is holding (the holdover value). When a start pulse arrives, the block stores the target and the signed gap between the start point and the target. It then works out how many fixed-size increments cover that gap and applies one increment per tick. The last tick lands exactly on the target, and the done flag then rises.

The increment per tick is chosen by a 6-bit rate code. The codes step geometrically from a very slow rate to a very fast one, and the code does not depend on any loop-bandwidth setting. A tick comes every `TICK_DIV` clock cycles. The step count comes from a sequential restoring divider, which takes `MAG_W` cycles after the start edge. A start pulse that arrives while a ramp is being prepared or is running begins a new ramp from wherever the output is at that moment.

The controller has four states. `ST_IDLE` passes the holdover word through. `ST_DIVIDE` computes the step count. `ST_RAMP` applies one increment per tick. `ST_HOLD` holds the target with done raised. The transitions are named as follows:
- `go_zero`: any state moves to `ST_HOLD` on a start pulse with a zero gap.
- `go_ramp`: any state moves to `ST_DIVIDE` on a start pulse with a non-zero gap.
- `div_done`: `ST_DIVIDE` moves to `ST_RAMP` when the divider finishes.
- `land`: `ST_RAMP` moves to `ST_HOLD` on the final tick.

In every other case the block stays in its current state.

Top module: `freq_ramp_gen`

## Requirements
- R1: After reset `freq_o` is 0 and `done_o` is 0. While no ramp has been started, `freq_o` equals the `cur_freq_i` value sampled at the previous rising edge.
- R2: A start pulse with a non-zero gap produces ceil(|target - base| / inc) ticks. The final tick sets `freq_o` exactly to the target, and `done_o` rises at that same edge. Both then hold until the next start pulse.
- R3: Every tick except the last changes `freq_o` by exactly one increment. The last tick changes it by the leftover amount, which lies between 1 and the increment.
- R4: Rate code k, for k from 0 to 39, selects the per-tick increment (4 + k mod 4) shifted left by floor(k/4). Codes 40 to 63 use the increment of code 39.
- R5: The first tick is applied at the (MAG_W + TICK_DIV + 1)-th rising edge after the start edge, where MAG_W = FW + 1. Later ticks are applied every TICK_DIV edges.
- R6: A start pulse whose target equals its base value raises `done_o` at the start edge itself, so it is visible in the following cycle. `freq_o` then equals the base value and does not change.
- R7: The base value is `cur_freq_i` when a start arrives in `ST_IDLE` or `ST_HOLD`. It is the present `freq_o` when a start arrives in `ST_DIVIDE` or `ST_RAMP`, so the output does not jump on a restart.
- R8: Target, rate code and `cur_freq_i` are sampled only on the start edge. Changing them during a ramp has no effect on `freq_o` or `done_o`.
- R9: The ramp runs downward when the target is below the base. During a ramp the output never moves away from the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a ramp |
| cur_freq_i | input | FW | Present holdover frequency word (signed) |
| tgt_freq_i | input | FW | Target frequency word (signed) |
| rate_sel_i | input | RATE_W | Ramp rate code |
| freq_o | output | FW | Ramped frequency word (signed) |
| done_o | output | 1 | High while the target is being held |

## Verification
The results fall due at different edges after a stimulus:
- The pass-through of the holdover value, the zero-gap done and the restart base are all due one edge after the stimulus.
- The first increment is due MAG_W + TICK_DIV + 1 edges after the start, and each later increment follows TICK_DIV edges after the one before.
- `done_o` rises on the same edge as the final increment.

The bench has a reference model that updates its expected output on each rising edge, using only the inputs the bench drove. The output is compared with this model at every falling edge, so each of these delays is checked at its exact cycle rather than just before the output settles. Each scenario also checks the final value and the done flag explicitly once its ramp has ended.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_RAMP   = 2'd2,
        ST_HOLD   = 2'd3
    } ramp_state_t;

    // Per-tick increment for rate index k: mantissa 4..7, exponent k/4 (R4)
    function automatic int unsigned rate_step(input int unsigned k);
        int unsigned mant;
        int unsigned expo;
        mant = 32'd4 + (k % 32'd4);
        expo = k / 32'd4;
        return mant << expo;
    endfunction

endpackage

// File: rtl/ramp_rate_lut.sv
module ramp_rate_lut #(
    parameter int RATE_W  = 6,
    parameter int N_RATES = 40,
    parameter int INC_W   = 16
) (
    input  logic [RATE_W-1:0] sel_i,
    output logic [INC_W-1:0]  inc_o
);
    localparam int N_CODES = 1 << RATE_W;
    localparam int LAST    = N_RATES - 1;

    logic [INC_W-1:0] table_w [N_CODES];

    // Every code gets an entry; codes past the last rate reuse it (R4)
    for (genvar g = 0; g < N_CODES; g++) begin : g_entry
        localparam int IDX = (g < N_RATES) ? g : LAST;
        assign table_w[g] = INC_W'(ramp_pkg::rate_step(IDX));
    end

    assign inc_o = table_w[sel_i];

endmodule

// File: rtl/ramp_div.sv
module ramp_div #(
    parameter int MAG_W = 25,
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [MAG_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic [MAG_W-1:0] quo_o,
    output logic [DVS_W-1:0] rem_o,
    output logic             ready_o
);
    localparam int CNT_W = $clog2(MAG_W + 1);

    logic [MAG_W-1:0] quo_q;
    logic [DVS_W-1:0] rem_q;
    logic [DVS_W-1:0] dvs_q;
    logic [CNT_W-1:0] cnt_q;

    logic [DVS_W:0]   partial_w;
    logic             fits_w;
    logic [DVS_W:0]   reduced_w;

    assign partial_w = {rem_q, quo_q[MAG_W-1]};
    assign fits_w    = partial_w >= {1'b0, dvs_q};
    assign reduced_w = fits_w ? (partial_w - {1'b0, dvs_q}) : partial_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            quo_q <= dividend_i;
            rem_q <= '0;
            dvs_q <= divisor_i;
            cnt_q <= CNT_W'(MAG_W);
        end else if (cnt_q != '0) begin
            quo_q <= {quo_q[MAG_W-2:0], fits_w};
            rem_q <= reduced_w[DVS_W-1:0];
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign quo_o   = quo_q;
    assign rem_o   = rem_q;
    assign ready_o = (cnt_q == '0);

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (rem_q < dvs_q)); // R3

endmodule

// File: rtl/ramp_tick.sv
module ramp_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (restart_i) begin
            cnt_q <= RELOAD;
        end else if (run_i) begin
            cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
        end
    end

    assign tick_o = run_i && !restart_i && (cnt_q == '0);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o && (TICK_DIV > 1) |=> !tick_o); // R5

endmodule

// File: rtl/freq_ramp_gen.sv
module freq_ramp_gen #(
    parameter int FW       = 24,
    parameter int RATE_W   = 6,
    parameter int N_RATES  = 40,
    parameter int INC_W    = 16,
    parameter int TICK_DIV = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic signed [FW-1:0]     cur_freq_i,
    input  logic signed [FW-1:0]     tgt_freq_i,
    input  logic        [RATE_W-1:0] rate_sel_i,
    output logic signed [FW-1:0]     freq_o,
    output logic                     done_o
);
    import ramp_pkg::*;

    localparam int MAG_W  = FW + 1;
    localparam int PROD_W = MAG_W + INC_W;

    ramp_state_t state_q, state_d;

    logic signed [FW-1:0]    out_q;
    logic signed [FW-1:0]    tgt_q;
    logic                    down_q;
    logic [INC_W-1:0]        inc_q;
    logic [MAG_W-1:0]        mag_q;
    logic [MAG_W-1:0]        steps_q;

    logic                    busy_w;
    logic signed [FW-1:0]    base_w;
    logic signed [MAG_W-1:0] gap_w;
    logic [MAG_W-1:0]        mag_w;
    logic                    gap_zero_w;
    logic [INC_W-1:0]        inc_sel_w;

    logic [MAG_W-1:0]        quo_w;
    logic [INC_W-1:0]        rem_w;
    logic                    div_ready_w;
    logic                    tick_w;
    logic                    last_w;
    logic                    enter_ramp_w;
    logic [INC_W-1:0]        amt_w;
    logic signed [MAG_W-1:0] stepped_w;

    // base and signed gap sampled at the start edge (R7, R8)
    assign busy_w     = (state_q == ST_DIVIDE) || (state_q == ST_RAMP);
    assign base_w     = busy_w ? out_q : cur_freq_i;
    assign gap_w      = MAG_W'(tgt_freq_i) - MAG_W'(base_w);
    assign mag_w      = gap_w[MAG_W-1] ? MAG_W'(-gap_w) : MAG_W'(gap_w);
    assign gap_zero_w = (gap_w == '0);

    ramp_rate_lut #(
        .RATE_W (RATE_W),
        .N_RATES(N_RATES),
        .INC_W  (INC_W)
    ) u_lut (
        .sel_i(rate_sel_i),
        .inc_o(inc_sel_w)
    );

    ramp_div #(
        .MAG_W(MAG_W),
        .DVS_W(INC_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start_i && !gap_zero_w),
        .dividend_i(mag_w),
        .divisor_i (inc_sel_w),
        .quo_o     (quo_w),
        .rem_o     (rem_w),
        .ready_o   (div_ready_w)
    );

    assign enter_ramp_w = !start_i && (state_q == ST_DIVIDE) && div_ready_w;

    ramp_tick #(
        .TICK_DIV(TICK_DIV)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(enter_ramp_w),
        .run_i    (state_q == ST_RAMP && !start_i),
        .tick_o   (tick_w)
    );

    // final tick takes the leftover when the division was not exact (R3)
    assign last_w    = (steps_q == MAG_W'(1));
    assign amt_w     = (last_w && rem_w != '0) ? rem_w : inc_q;
    assign stepped_w = down_q ? (MAG_W'(out_q) - MAG_W'(amt_w))
                              : (MAG_W'(out_q) + MAG_W'(amt_w));

    // next-state logic: go_zero, go_ramp, div_done, land
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = gap_zero_w ? ST_HOLD : ST_DIVIDE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_DIVIDE: state_d = div_ready_w ? ST_RAMP : ST_DIVIDE;
                ST_RAMP:   state_d = (tick_w && last_w) ? ST_HOLD : ST_RAMP;
                ST_HOLD:   state_d = ST_HOLD;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            tgt_q   <= '0;
            down_q  <= 1'b0;
            inc_q   <= '0;
            mag_q   <= '0;
            steps_q <= '0;
        end else if (start_i) begin
            out_q   <= base_w;
            tgt_q   <= tgt_freq_i;
            down_q  <= gap_w[MAG_W-1];
            inc_q   <= inc_sel_w;
            mag_q   <= mag_w;
        end else begin
            unique case (state_q)
                ST_IDLE: out_q <= cur_freq_i;
                ST_DIVIDE: begin
                    if (div_ready_w)
                        steps_q <= quo_w + MAG_W'(rem_w != '0);
                end
                ST_RAMP: begin
                    if (tick_w) begin
                        out_q   <= FW'(stepped_w);
                        steps_q <= steps_q - 1'b1;
                    end
                end
                ST_HOLD: out_q <= out_q;
                default: out_q <= out_q;
            endcase
        end
    end

    assign freq_o = out_q;
    assign done_o = (state_q == ST_HOLD);

    // ---------------- assertions ----------------
    logic [PROD_W-1:0] recon_w;
    assign recon_w = PROD_W'(quo_w) * PROD_W'(inc_q) + PROD_W'(rem_w);

    AST_IDLE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> (freq_o == $past(cur_freq_i))); // R1

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE && div_ready_w && !start_i) |-> (recon_w == PROD_W'(mag_q))); // R2

    AST_LAND_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && tick_w && last_w && !start_i) |=> (done_o && freq_o == tgt_q)); // R2

    AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (freq_o == tgt_q)); // R2

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && tick_w && !last_w && !start_i) |=>
        ((MAG_W'(freq_o) - MAG_W'($past(freq_o))) ==
         (down_q ? MAG_W'(-MAG_W'(inc_q)) : MAG_W'(inc_q)))); // R3

    AST_ZERO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_w && tgt_freq_i == cur_freq_i) |=>
        (done_o && freq_o == $past(cur_freq_i))); // R6

    AST_RESTART_SMOOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_w) |=> (freq_o == $past(freq_o))); // R7

    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && !start_i) |=>
        (down_q ? (freq_o >= tgt_q) : (freq_o <= tgt_q))); // R9

endmodule

// File: tb/tb_freq_ramp_gen.sv
module tb_freq_ramp_gen;
    localparam int CLK_PERIOD = 10;
    localparam int FW       = 24;
    localparam int RATE_W   = 6;
    localparam int TICK_DIV = 4;
    localparam int MAG_W    = FW + 1;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start_i = 1'b0;
    logic signed [FW-1:0]     cur_freq_i = '0;
    logic signed [FW-1:0]     tgt_freq_i = '0;
    logic        [RATE_W-1:0] rate_sel_i = '0;
    logic signed [FW-1:0]     freq_o;
    logic                     done_o;

    freq_ramp_gen #(
        .FW(FW), .RATE_W(RATE_W), .N_RATES(40), .INC_W(16), .TICK_DIV(TICK_DIV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cur_freq_i(cur_freq_i), .tgt_freq_i(tgt_freq_i), .rate_sel_i(rate_sel_i),
        .freq_o(freq_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference model
    int m_out, m_tgt, m_inc, m_wait;
    bit m_busy, m_hold, m_done;

    function automatic int model_inc(input int code);
        int k;
        k = (code > 39) ? 39 : code;          // R4 clamp
        return (4 + (k % 4)) << (k / 4);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 0; m_done = 0; m_busy = 0; m_hold = 0; m_wait = 0;
        end else if (start_i) begin
            int base;
            base  = m_busy ? m_out : int'(cur_freq_i);
            m_out = base;
            m_tgt = int'(tgt_freq_i);
            m_inc = model_inc(int'(rate_sel_i));
            if (m_tgt == base) begin
                m_done = 1; m_busy = 0; m_hold = 1;
            end else begin
                m_done = 0; m_busy = 1; m_hold = 0; m_wait = MAG_W + TICK_DIV;
            end
        end else if (m_busy) begin
            if (m_wait == 0) begin
                int d, ad;
                d  = m_tgt - m_out;
                ad = (d < 0) ? -d : d;
                if (ad <= m_inc) begin
                    m_out = m_tgt; m_busy = 0; m_done = 1; m_hold = 1;
                end else begin
                    m_out = m_out + ((d > 0) ? m_inc : -m_inc);
                end
                m_wait = TICK_DIV - 1;
            end else begin
                m_wait = m_wait - 1;
            end
        end else if (!m_hold) begin
            m_out = int'(cur_freq_i);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(freq_o) == m_out, {tag, " freq"}, int'(freq_o), m_out);
            chk(done_o == m_done, {tag, " done"}, int'(done_o), int'(m_done));
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic kick(input int cur, input int tgt, input int code);
        @(negedge clk);
        cur_freq_i = FW'(cur); tgt_freq_i = FW'(tgt); rate_sel_i = RATE_W'(code);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim && !done_o; i++) @(negedge clk);
    endtask

    task automatic ramp_case(input string t, input int cur, input int tgt, input int code);
        tag = t;
        kick(cur, tgt, code);
        wait_done(4000);
        chk(done_o == 1'b1, {t, " end done"}, int'(done_o), 1);
        chk(int'(freq_o) == tgt, {t, " end target"}, int'(freq_o), tgt);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(freq_o == '0, "R1 reset freq", int'(freq_o), 0);
        chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        // R1 idle pass-through
        tag = "R1";
        cur_freq_i = 24'sd123;
        @(negedge clk); @(negedge clk);
        chk(int'(freq_o) == 123, "R1 idle track", int'(freq_o), 123);
        cur_freq_i = -24'sd77;
        @(negedge clk);
        chk(int'(freq_o) == -77, "R1 idle track neg", int'(freq_o), -77);

        // R2 R3 R5: upward, inexact (inc 4, gap 43 -> 11 ticks)
        ramp_case("R2 R3 R5 up", 1000, 1043, 0);
        // R9: downward, exact (code 3 inc 7, 12 ticks)
        ramp_case("R9 R3 down", 5000, 5000 - 84, 3);
        // crossing zero upward
        ramp_case("R2 R9 cross", -300, 200, 13);
        // R4 clamp: codes 39, 45, 63 share the fastest increment 3584
        ramp_case("R4 code39", 0, 3584*3 + 100, 39);
        ramp_case("R4 code63", 0, -(3584*3 + 100), 63);
        ramp_case("R4 code45", 10, 10 + 3584*2, 45);
        ramp_case("R4 code20", 0, 128*3 + 5, 20);

        // R6 zero gap
        tag = "R6";
        kick(777, 777, 5);
        chk(done_o == 1'b1, "R6 zero gap done", int'(done_o), 1);
        chk(int'(freq_o) == 777, "R6 zero gap freq", int'(freq_o), 777);
        repeat (4) @(negedge clk);

        // R7 restart mid-ramp from current output
        tag = "R7";
        kick(0, 4000, 8);
        repeat (60) @(negedge clk);
        kick(-999, 600, 20);     // cur ignored: busy, so base = output
        wait_done(4000);
        chk(int'(freq_o) == 600, "R7 restart target", int'(freq_o), 600);
        // R7 restart during divide
        kick(600, 100, 6);
        repeat (5) @(negedge clk);
        kick(50000, 900, 10);
        wait_done(4000);
        chk(int'(freq_o) == 900, "R7 divide restart target", int'(freq_o), 900);

        // R8 inputs changing during ramp are ignored
        tag = "R8";
        kick(200, 260, 1);
        repeat (35) @(negedge clk);
        cur_freq_i = 24'sd9999; tgt_freq_i = -24'sd5; rate_sel_i = 6'd63;
        wait_done(4000);
        chk(int'(freq_o) == 260, "R8 ignored target", int'(freq_o), 260);
        repeat (5) @(negedge clk);
        chk(int'(freq_o) == 260, "R8 hold after done", int'(freq_o), 260);

        // start from HOLD uses cur_freq_i as base
        ramp_case("R7 from hold", -40, -10, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule